// File: doc/BRIEF.md
# DMA Channel Request Controller

This block holds the control state of one DMA channel and decides when the channel asks for the bus. A request can come from three places: an external pin, a strobe from an on-chip peripheral, or the channel itself when it is set to auto-request. The pin is synchronized first. It can then be read as a level, either active-high or active-low, or as a rising or falling edge. The mode selection exists only on the lower-numbered channels.

Once a request is seen, the channel raises a bus request and waits for a grant. It then counts the beats that the datapath reports through a per-beat done pulse. In cycle-steal mode the bus is given back after every transfer unit. In burst mode the bus is held until the whole count is done, and burst mode only takes effect while a separate permit bit is set. When the 24-bit transfer count reaches zero, a sticky end flag is set. An interrupt is raised while that flag and the interrupt enable are both 1. Address generation and data movement belong to the datapath and are not part of this block.

Software uses a small register port. Select 0 is the control word and select 1 is the transfer count. Reads are registered.

Top module: `dmach_ctrl`

## Requirements
- R1: After reset the control word and the count read as 0, and bus_req and irq are both low.
- R2: Control word layout: bit0 enable, bit1 end flag, bit2 irq enable, bits4:3 unit size, bit5 burst select, bit6 burst permit, bits8:7 request mode, bits10:9 source (00 auto, 01 peripheral, 10 pin). Select 1 holds the count in its low 24 bits. The request mode is stored and read back on channels below MODE_CHANS. On other channels it always reads 0, and writes to it have no effect.
- R3: With source pin, mode 10 requests while the synchronized pin is high, and mode 00 requests while it is low. No bus request is made while the pin sits at the inactive level.
- R4: With source pin, mode 11 latches one pending request on a rising edge and mode 01 latches one on a falling edge. A single edge yields exactly one transfer unit, and a steady pin yields none.
- R5: With source peripheral, the pin is ignored and each periph_req pulse yields one unit. With source auto, the pin is ignored and the channel requests whenever it is enabled with a nonzero count.
- R6: In cycle-steal mode (bit5 = 0), bus_req goes low for at least one cycle after every transfer unit.
- R7: In burst mode (bit5 = 1 and bit6 = 1), bus_req stays high from the first grant until the count reaches zero.
- R8: With bit5 = 1 and bit6 = 0, the channel behaves as cycle-steal.
- R9: Unit size 00, 01 and 10 takes one beat per unit, and 11 takes four beats per unit. The count drops by one per completed unit.
- R10: The end flag is set when the count reaches zero. Writing 1 to bit1 keeps it set, and writing 0 clears it.
- R11: irq is high exactly while the end flag and the irq enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write select: 0 control, 1 count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 control, 1 count |
| rd_data | output | 32 | Registered read data, one cycle after rd_sel |
| req_pin | input | 1 | Raw external request pin, asynchronous |
| periph_req | input | 1 | One-cycle request strobe from a peripheral |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| beat_done | input | 1 | One-cycle pulse per completed datapath beat |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The assertions assume that beat_done pulses only while the channel owns the bus, and at most once per cycle. They also assume that the count is not rewritten while a transfer is in flight, and that bus_gnt is only acted on while bus_req is high. The bench's responder task keeps to these rules. It raises bus_gnt only after it has seen bus_req, and it pulses beat_done only in a cycle that follows a sampled request-and-grant. Every register write happens with the enable bit clear, or before the first request.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_HIGH = 2'b10,
    DET_RISE = 2'b11
  } det_mode_e;

  typedef enum logic [1:0] {
    SRC_AUTO   = 2'b00,
    SRC_PERIPH = 2'b01,
    SRC_PIN    = 2'b10,
    SRC_NONE   = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_XFER = 2'b10
  } st_e;

  // control word bit positions
  localparam int B_GO    = 0;
  localparam int B_END   = 1;
  localparam int B_IE    = 2;
  localparam int B_SIZE  = 3;
  localparam int B_BURST = 5;
  localparam int B_BOK   = 6;
  localparam int B_MODE  = 7;
  localparam int B_SRC   = 9;
  localparam int CTL_W   = 11;
endpackage

// File: rtl/dmach_reqdet.sv
module dmach_reqdet
  import dmach_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin,
  input  logic      per_strobe,
  input  src_e      src,
  input  det_mode_e mode,
  input  logic      take,
  output logic      want
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, pend_q;
  logic s, rise, fall, edge_hit, lvl_hit, hit;

  assign s        = sync_q[MSB];
  assign rise     = s & ~prev_q;
  assign fall     = ~s & prev_q;
  assign edge_hit = mode[1] ? rise : fall;
  assign lvl_hit  = mode[1] ? s : ~s;
  assign hit      = ((src == SRC_PERIPH) & per_strobe) |
                    ((src == SRC_PIN) & mode[0] & edge_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= s;
      pend_q <= hit | (pend_q & ~take);
    end
  end

  always_comb begin
    unique case (src)
      SRC_AUTO:   want = 1'b1;
      SRC_PERIPH: want = pend_q;
      SRC_PIN:    want = mode[0] ? pend_q : lvl_hit;
      default:    want = 1'b0;
    endcase
  end

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !take) |=> pend_q);
endmodule

// File: rtl/dmach_xfer.sv
module dmach_xfer
  import dmach_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int LINE_BEATS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             burst_eff,
  input  logic [1:0]       size,
  input  logic             want,
  input  logic             gnt,
  input  logic             beat_done,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             end_clr,
  output logic             bus_req,
  output logic             take,
  output logic [CNT_W-1:0] cnt,
  output logic             end_flag
);
  localparam int BEAT_W = $clog2(LINE_BEATS);

  st_e              st_q;
  logic [BEAT_W-1:0] beat_q;
  logic [CNT_W-1:0] cnt_q;
  logic             end_q, req_q, active, last;

  assign active   = go & ~end_q & (cnt_q != '0);
  assign last     = (size == 2'b11) ? (beat_q == BEAT_W'(LINE_BEATS - 1)) : 1'b1;
  assign take     = (st_q == ST_REQ) & gnt;
  assign bus_req  = req_q;
  assign cnt      = cnt_q;
  assign end_flag = end_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      cnt_q  <= '0;
      end_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (end_clr) end_q <= 1'b0;
      if (cnt_ld) cnt_q <= cnt_wdata;
      unique case (st_q)
        ST_IDLE: if (active && want) begin
          st_q  <= ST_REQ;
          req_q <= 1'b1;
        end
        ST_REQ: if (gnt) begin
          st_q   <= ST_XFER;
          beat_q <= '0;
        end
        ST_XFER: if (beat_done) begin
          if (last) begin
            cnt_q  <= cnt_q - 1'b1;
            beat_q <= '0;
            if (cnt_q == CNT_W'(1)) begin
              end_q <= 1'b1;
              req_q <= 1'b0;
              st_q  <= ST_IDLE;
            end else if (!burst_eff) begin
              req_q <= 1'b0;
              st_q  <= ST_IDLE;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && beat_done && last && !burst_eff) |=> !bus_req);
  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && burst_eff && !(beat_done && last && cnt_q == CNT_W'(1)))
      |=> bus_req);
  // R10
  end_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (end_q && !end_clr) |=> end_q);
  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_ld |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int CHAN_ID     = 0,
  parameter int MODE_CHANS  = 4,
  parameter int CNT_W       = 24,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LINE_BEATS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              req_pin,
  input  logic              periph_req,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              beat_done,
  output logic              irq
);
  logic       ctl_we, cnt_ld, end_clr, go_q, ie_q, burst_q, bok_q;
  logic [1:0] size_q;
  src_e       src_q;
  det_mode_e  mode_q;
  logic       want, take, end_flag;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] rd_q;
  logic       unused_hi;

  assign ctl_we    = wr_en & ~wr_sel;
  assign cnt_ld    = wr_en & wr_sel;
  assign end_clr   = ctl_we & ~wr_data[B_END];
  assign unused_hi = &{1'b0, wr_data[DATA_W-1:CNT_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q    <= 1'b0;
      ie_q    <= 1'b0;
      burst_q <= 1'b0;
      bok_q   <= 1'b0;
      size_q  <= 2'b00;
      src_q   <= SRC_AUTO;
    end else if (ctl_we) begin
      go_q    <= wr_data[B_GO];
      ie_q    <= wr_data[B_IE];
      burst_q <= wr_data[B_BURST];
      bok_q   <= wr_data[B_BOK];
      size_q  <= wr_data[B_SIZE +: 2];
      src_q   <= src_e'(wr_data[B_SRC +: 2]);
    end
  end

  generate
    if (CHAN_ID < MODE_CHANS) begin : g_mode
      always_ff @(posedge clk) begin
        if (rst) mode_q <= DET_LOW;
        else if (ctl_we) mode_q <= det_mode_e'(wr_data[B_MODE +: 2]);
      end
    end else begin : g_nomode
      assign mode_q = DET_LOW;
    end
  endgenerate

  dmach_reqdet #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst(rst), .pin(req_pin), .per_strobe(periph_req),
    .src(src_q), .mode(mode_q), .take(take), .want(want)
  );

  dmach_xfer #(.CNT_W(CNT_W), .LINE_BEATS(LINE_BEATS)) u_xfer (
    .clk(clk), .rst(rst), .go(go_q), .burst_eff(burst_q & bok_q),
    .size(size_q), .want(want), .gnt(bus_gnt), .beat_done(beat_done),
    .cnt_ld(cnt_ld), .cnt_wdata(wr_data[CNT_W-1:0]), .end_clr(end_clr),
    .bus_req(bus_req), .take(take), .cnt(cnt), .end_flag(end_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_sel) rd_q <= DATA_W'(cnt);
    else rd_q <= DATA_W'({src_q, mode_q, bok_q, burst_q, size_q, ie_q, end_flag, go_q});
  end

  assign rd_data = rd_q;
  assign irq     = end_flag & ie_q;

  // R11
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(end_flag) && ie_q) |-> irq);
endmodule

// File: tb/sim_dmach_ctrl.sv
`timescale 1ns/100ps
module sim_dmach_ctrl;
  logic clk = 1'b0;
  logic rst, wr_en, wr_sel, rd_sel, req_pin, periph_req, bus_gnt, beat_done;
  logic [31:0] wr_data, rd_data, rd_data1;
  logic bus_req, irq, bus_req1, irq1;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dmach_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .req_pin(req_pin), .periph_req(periph_req),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .beat_done(beat_done), .irq(irq)
  );

  dmach_ctrl #(.CHAN_ID(5)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data1), .req_pin(req_pin), .periph_req(periph_req),
    .bus_req(bus_req1), .bus_gnt(1'b0), .beat_done(1'b0), .irq(irq1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit go, input bit ie, input logic [1:0] sz,
                                      input bit burst, input bit bok,
                                      input logic [1:0] mode, input logic [1:0] src);
    return {21'd0, src, mode, bok, burst, sz, ie, 1'b0, go};
  endfunction

  task automatic do_reset(input logic pin_lvl);
    rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    req_pin = pin_lvl; periph_req = 0; bus_gnt = 0; beat_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk); rd_sel = sel;
    @(posedge clk); #1 d = rd_data;
  endtask

  task automatic serve(input int beats, input int limit, output int given, output int rises);
    logic br, pbr;
    given = 0; rises = 0; pbr = 1'b0;
    for (int c = 0; c < limit && given < beats; c++) begin
      @(negedge clk);
      br = bus_req;
      if (br && !pbr) rises++;
      pbr = br;
      if (beat_done) begin
        beat_done = 1'b0;
        if (!br) bus_gnt = 1'b0;
      end else if (br && bus_gnt) begin
        beat_done = 1'b1;
        given++;
      end else begin
        bus_gnt = br;
      end
    end
    @(negedge clk); beat_done = 1'b0; bus_gnt = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset(1'b0);
    chk("R1 bus_req", {31'd0, bus_req}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(1'b0, d); chk("R1 ctl", d, 0);
    rd(1'b1, d); chk("R1 cnt", d, 0);
  endtask

  task automatic t_mode_rb();
    logic [31:0] d;
    do_reset(1'b0);
    wr(1'b0, mk(0, 0, 2'b00, 0, 0, 2'b11, 2'b10));
    rd(1'b0, d);
    chk("R2 mode ch0", {30'd0, d[8:7]}, 3);
    chk("R2 src ch0", {30'd0, d[10:9]}, 2);
    chk("R2 mode ch5", {30'd0, rd_data1[8:7]}, 0);
  endtask

  task automatic t_cs_auto();
    logic [31:0] d; int g, r;
    do_reset(1'b0);
    wr(1'b1, 3);
    wr(1'b0, mk(1, 1, 2'b01, 0, 0, 2'b10, 2'b00));
    serve(3, 200, g, r);
    chk("R5 auto ignores pin", g, 3);
    chk("R6 cycle-steal rises", r, 3);
    rd(1'b1, d); chk("R9 cnt zero", d, 0);
    rd(1'b0, d); chk("R10 end set", {31'd0, d[1]}, 1);
    chk("R11 irq on", {31'd0, irq}, 1);
    wr(1'b0, mk(0, 1, 2'b01, 0, 0, 2'b10, 2'b00) | 32'h2);
    rd(1'b0, d); chk("R10 write 1 keeps", {31'd0, d[1]}, 1);
    wr(1'b0, mk(0, 1, 2'b01, 0, 0, 2'b10, 2'b00));
    rd(1'b0, d); chk("R10 write 0 clears", {31'd0, d[1]}, 0);
    chk("R11 irq off", {31'd0, irq}, 0);
  endtask

  task automatic t_burst(input bit bok);
    int g, r;
    do_reset(1'b0);
    wr(1'b1, 4);
    wr(1'b0, mk(1, 0, 2'b10, 1, bok, 2'b00, 2'b00));
    serve(4, 200, g, r);
    chk("R9 size10 units", g, 4);
    if (bok) chk("R7 burst single request", r, 1);
    else     chk("R8 burst w/o permit rises", r, 4);
  endtask

  task automatic t_line();
    logic [31:0] d; int g, r;
    do_reset(1'b0);
    wr(1'b1, 2);
    wr(1'b0, mk(1, 0, 2'b11, 0, 0, 2'b00, 2'b00));
    serve(4, 100, g, r);
    chk("R9 line first unit rises", r, 1);
    rd(1'b1, d); chk("R9 cnt after 4 beats", d, 1);
    rd(1'b0, d); chk("R9 end not yet", {31'd0, d[1]}, 0);
    serve(3, 100, g, r);
    rd(1'b0, d); chk("R9 end not after 7 beats", {31'd0, d[1]}, 0);
    serve(1, 100, g, r);
    rd(1'b0, d); chk("R9 end after 8 beats", {31'd0, d[1]}, 1);
  endtask

  task automatic t_ie0();
    logic [31:0] d; int g, r;
    do_reset(1'b0);
    wr(1'b1, 1);
    wr(1'b0, mk(1, 0, 2'b00, 0, 0, 2'b00, 2'b00));
    serve(1, 100, g, r);
    rd(1'b0, d); chk("R10 end set ie0", {31'd0, d[1]}, 1);
    chk("R11 no irq when disabled", {31'd0, irq}, 0);
  endtask

  task automatic t_level(input bit high);
    logic [31:0] d; int g, r;
    do_reset(~high);
    wr(1'b1, 2);
    wr(1'b0, mk(1, 0, 2'b00, 0, 0, high ? 2'b10 : 2'b00, 2'b10));
    serve(1, 20, g, r);
    chk("R3 idle at inactive level", r, 0);
    req_pin = high;
    serve(2, 100, g, r);
    chk("R3 level units", g, 2);
    rd(1'b0, d); chk("R3 end after level", {31'd0, d[1]}, 1);
  endtask

  task automatic t_edge(input bit rising);
    logic [31:0] d; int g, r;
    do_reset(~rising);
    repeat (6) @(negedge clk);
    wr(1'b1, 5);
    wr(1'b0, mk(1, 0, 2'b00, 0, 0, rising ? 2'b11 : 2'b01, 2'b10));
    serve(1, 15, g, r);
    chk("R4 steady pin no request", r, 0);
    @(negedge clk) req_pin = rising;
    @(negedge clk) req_pin = ~rising;
    serve(5, 60, g, r);
    chk("R4 one edge one unit", g, 1);
    rd(1'b1, d); chk("R4 cnt after edge", d, 4);
  endtask

  task automatic t_periph();
    logic [31:0] d; int g, r;
    do_reset(1'b0);
    wr(1'b1, 3);
    wr(1'b0, mk(1, 0, 2'b00, 0, 0, 2'b11, 2'b01));
    for (int i = 0; i < 10; i++) @(negedge clk) req_pin = ~req_pin;
    serve(1, 20, g, r);
    chk("R5 periph ignores pin", r, 0);
    @(negedge clk) periph_req = 1'b1;
    @(negedge clk) periph_req = 1'b0;
    serve(3, 60, g, r);
    chk("R5 one strobe one unit", g, 1);
    rd(1'b1, d); chk("R5 cnt after strobe", d, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_mode_rb();
    t_cs_auto();
    t_burst(1'b1);
    t_burst(1'b0);
    t_line();
    t_ie0();
    t_level(1'b1);
    t_level(1'b0);
    t_edge(1'b1);
    t_edge(1'b0);
    t_periph();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule